// File: doc/BRIEF.md
# Addressed Multi-Listener UART Receiver

This block receives asynchronous serial frames and can filter them by tag, so that several listeners share one line driven by a single sender. Each frame is tagged as either an address or a data byte. In nine-bit mode the tag is the ninth data bit. In eight-bit mode the tag is the stop bit. While the filter-enable bit is set, the block accepts only address-tagged frames and drops data frames without touching any register. The host compares each accepted address with its own. When it sees a match, it clears the filter-enable bit and from then on receives the following data frames as ordinary bytes.

The line is sampled with a tick that runs at sixteen times the bit rate. A small register port gives the host access to the block. Address 0 returns the received byte when read, and loads a transmit holding register when written. Address 1 is the status and control byte. Address 2 returns the received ninth bit.

Top module: `mpuart_rx`

## Requirements
- R1: A bit lasts 16 `os_tick` periods, and data bits arrive LSB first. The start bit is sampled again near its middle. If the line is high there, the block returns to idle and records nothing. After a frame whose stop bit was low, the block waits for the line to go high before it looks for a new start bit.
- R2: In nine-bit mode (`nine_bit`=1), a ninth bit of 1 tags the frame as an address and 0 tags it as data. A stored frame whose stop bit is 0 sets the framing-error flag.
- R3: In eight-bit mode, a stop bit of 1 tags the frame as an address and 0 tags it as data. With filtering off, a stored data byte therefore sets the framing-error flag, which is status bit 4.
- R4: While filter-enable (status bit 0) is 1, a data-tagged frame leaves the received byte, the ninth bit and the status flags unchanged.
- R5: An address-tagged frame is always accepted, and it sets receive-complete (status bit 7), even while filter-enable is 1.
- R6: A read of address 0 returns the received byte and clears receive-complete. A write to address 0 loads `tx_hold` and does not change the byte that address 0 reads back.
- R7: The status byte holds, from bit 7 down to bit 0: receive-complete, transmit-complete, transmit-empty, framing-error, overrun, a reserved bit that reads 0, double-speed, filter-enable. After reset the status byte reads 0x20.
- R8: A write to address 1 updates only bits 6, 1 and 0. The other status bits keep their values.
- R9: When a frame is accepted while receive-complete is still 1, the overrun flag (bit 3) is set, and the byte, the ninth bit and the framing-error flag are kept. The next frame that is stored clears overrun.
- R10: Bit 0 of address 2 returns the ninth bit of the stored frame, which is 0 for eight-bit frames. Its other bits are 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input; idles high |
| os_tick | input | 1 | Oversampling strobe, 16 per bit |
| nine_bit | input | 1 | 1 selects nine data bits; latched at each start bit |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (the read side effect is taken at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tx_hold | output | 8 | Transmit holding register |
| rx_byte | output | 8 | Received data register |
| rx_full | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Framing-error flag |
| overrun_flag | output | 1 | Overrun flag |

## Verification
The hardest situation to reach from the ports is a data frame that arrives while filtering is on, right after an address was accepted. The drop is visible only as the absence of change, so the bench leaves distinctive data in place before each filtered frame and then reads back every register. Overrun needs a second accepted frame before the host reads. The random phase reaches it by skipping the data read on some frames, and it mixes filter settings, modes and stop-bit values so that dropped, stored and overrun frames follow one another in every order.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  localparam int DATA_W = 8;
  localparam int WIDE_W = DATA_W + 1;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_AUX  = 2'd2;

  // status bit positions: a host decodes these
  localparam int ST_RXC = 7;
  localparam int ST_TXC = 6;
  localparam int ST_TXE = 5;
  localparam int ST_FE  = 4;
  localparam int ST_OVR = 3;
  localparam int ST_DBL = 1;
  localparam int ST_MPE = 0;

  typedef struct packed {
    logic [WIDE_W-1:0] bits;
    logic              stop;
    logic              nine;
  } rx_frame_t;

  // address tag: ninth bit in wide mode, stop bit otherwise
  function automatic logic tag_is_addr(input logic nine, input logic b9, input logic stop);
    return nine ? b9 : stop;
  endfunction

  function automatic logic [3:0] last_index(input logic nine);
    return nine ? 4'(WIDE_W - 1) : 4'(DATA_W - 1);
  endfunction

  function automatic logic [7:0] pack_status(
    input logic rxc, input logic txc, input logic txe, input logic fe,
    input logic ovr, input logic dbl, input logic mpe);
    logic [7:0] s;
    s = '0;
    s[ST_RXC] = rxc;
    s[ST_TXC] = txc;
    s[ST_TXE] = txe;
    s[ST_FE]  = fe;
    s[ST_OVR] = ovr;
    s[ST_DBL] = dbl;
    s[ST_MPE] = mpe;
    return s;
  endfunction

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mprx_frame.sv
module mprx_frame
  import mprx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      os_tick,
  input  logic      line,
  input  logic      nine_bit,
  output logic      frm_valid,
  output rx_frame_t frm,
  output logic      start_abort
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_REARM} rx_st_e;

  rx_st_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        idx_q;
  logic [WIDE_W-1:0] shreg_q;
  logic              nine_q;

  logic at_mid, at_end;
  assign at_mid      = os_tick && (cnt_q == MID);
  assign at_end      = os_tick && (cnt_q == LAST);
  assign start_abort = (st_q == S_START) && at_mid && line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      nine_q    <= 1'b0;
      frm_valid <= 1'b0;
      frm       <= '0;
    end else begin
      frm_valid <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (os_tick && !line) begin
            st_q  <= S_START;
            cnt_q <= '0;
          end
        end
        S_START: begin
          if (at_mid) begin
            cnt_q <= '0;
            if (line) begin
              st_q <= S_IDLE;
            end else begin
              st_q   <= S_DATA;
              idx_q  <= '0;
              nine_q <= nine_bit;
            end
          end else if (os_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (at_end) begin
            cnt_q          <= '0;
            shreg_q[idx_q] <= line;
            if (idx_q == last_index(nine_q)) st_q <= S_STOP;
            else                             idx_q <= idx_q + 1'b1;
          end else if (os_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_STOP: begin
          if (at_end) begin
            cnt_q     <= '0;
            frm_valid <= 1'b1;
            frm.bits  <= nine_q ? shreg_q : {1'b0, shreg_q[DATA_W-1:0]};
            frm.stop  <= line;
            frm.nine  <= nine_q;
            st_q      <= line ? S_IDLE : S_REARM;
          end else if (os_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_REARM: begin
          if (line) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_START_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |=> (st_q == S_IDLE) && !frm_valid); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid); // R1
  AST_LOW_STOP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm.stop) |-> (st_q == S_REARM)); // R1
endmodule

// File: rtl/mprx_regs.sv
module mprx_regs
  import mprx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  rx_frame_t         frm,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] tx_hold,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun_flag
);
  logic rxc_q, txc_q, txe_q, fe_q, ovr_q, dbl_q, mpe_q, b9_q;
  logic [DATA_W-1:0] data_q, txd_q;

  // named events
  logic rd_data, wr_data, wr_stat;
  logic frm_is_addr, frm_drop, frm_take, rxc_live, frm_store, frm_overrun;

  assign rd_data     = bus_rd && (bus_addr == ADR_DATA);
  assign wr_data     = bus_wr && (bus_addr == ADR_DATA);
  assign wr_stat     = bus_wr && (bus_addr == ADR_STAT);
  assign frm_is_addr = tag_is_addr(frm.nine, frm.bits[WIDE_W-1], frm.stop);
  assign frm_drop    = frm_valid && mpe_q && !frm_is_addr;
  assign frm_take    = frm_valid && !frm_drop;
  assign rxc_live    = rxc_q && !rd_data;
  assign frm_store   = frm_take && !rxc_live;
  assign frm_overrun = frm_take && rxc_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_q  <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      b9_q   <= 1'b0;
      data_q <= '0;
    end else if (frm_store) begin
      rxc_q  <= 1'b1;
      fe_q   <= !frm.stop;
      ovr_q  <= 1'b0;
      b9_q   <= frm.bits[WIDE_W-1];
      data_q <= frm.bits[DATA_W-1:0];
    end else begin
      if (frm_overrun) ovr_q <= 1'b1;
      if (rd_data)     rxc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_q <= 1'b0;
      txe_q <= 1'b1;
      dbl_q <= 1'b0;
      mpe_q <= 1'b0;
      txd_q <= '0;
    end else begin
      txe_q <= txe_q;
      if (wr_stat) begin
        txc_q <= bus_wdata[ST_TXC];
        dbl_q <= bus_wdata[ST_DBL];
        mpe_q <= bus_wdata[ST_MPE];
      end
      if (wr_data) txd_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_DATA: bus_rdata = data_q;
      ADR_STAT: bus_rdata = pack_status(rxc_q, txc_q, txe_q, fe_q, ovr_q, dbl_q, mpe_q);
      ADR_AUX:  bus_rdata = {{(DATA_W-1){1'b0}}, b9_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign tx_hold      = txd_q;
  assign rx_byte      = data_q;
  assign rx_full      = rxc_q;
  assign frame_err    = fe_q;
  assign overrun_flag = ovr_q;

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_drop && !rd_data) |=> $stable(data_q) && $stable(rxc_q) && $stable(fe_q)
                               && $stable(ovr_q) && $stable(b9_q)); // R4
  AST_ADDR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_is_addr) |=> rxc_q); // R5
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    frm_overrun |=> ovr_q && $stable(data_q) && $stable(fe_q)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !frm_take) |=> !rxc_q); // R6
  AST_FE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_store |=> (fe_q != $past(frm.stop))); // R3
  AST_STORE_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    frm_store |=> !ovr_q); // R9
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mprx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              nine_bit,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] tx_hold,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun_flag
);
  logic      line_s;
  logic      frm_valid;
  rx_frame_t frm;
  logic      start_abort;

  mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_line),
    .d_sync  (line_s)
  );

  mprx_frame #(.OS_RATE(OS_RATE)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .os_tick     (os_tick),
    .line        (line_s),
    .nine_bit    (nine_bit),
    .frm_valid   (frm_valid),
    .frm         (frm),
    .start_abort (start_abort)
  );

  mprx_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_valid    (frm_valid),
    .frm          (frm),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .tx_hold      (tx_hold),
    .rx_byte      (rx_byte),
    .rx_full      (rx_full),
    .frame_err    (frame_err),
    .overrun_flag (overrun_flag)
  );

  AST_ABORT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |=> !frm_valid); // R1
endmodule

// File: tb/sim_mpuart_rx.sv
`timescale 1ns/1ps
module sim_mpuart_rx;
  localparam int TPB = 64; // clocks per bit: 16 ticks x 4 clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic os_tick = 1'b0;
  logic nine_bit = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, tx_hold, rx_byte;
  logic rx_full, frame_err, overrun_flag;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  bit m_rxc, m_txc, m_fe, m_ovr, m_dbl, m_mpe, m_b9;
  logic [7:0] m_data;

  mpuart_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick), .nine_bit(nine_bit),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_hold(tx_hold), .rx_byte(rx_byte), .rx_full(rx_full),
    .frame_err(frame_err), .overrun_flag(overrun_flag)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  function automatic logic [7:0] exp_status();
    return {m_rxc, m_txc, 1'b1, m_fe, m_ovr, 1'b0, m_dbl, m_mpe};
  endfunction

  function automatic bit addr_tag(bit nine, logic [8:0] d9, bit stop);
    if (nine) return d9[8];
    return stop;
  endfunction

  function automatic void model_frame(bit nine, logic [8:0] d9, bit stop);
    if (m_mpe && !addr_tag(nine, d9, stop)) return;
    if (m_rxc) begin
      m_ovr = 1'b1;
    end else begin
      m_data = d9[7:0];
      m_b9   = nine ? d9[8] : 1'b0;
      m_fe   = !stop;
      m_ovr  = 1'b0;
      m_rxc  = 1'b1;
    end
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 2'd1) begin
      m_txc = d[6]; m_dbl = d[1]; m_mpe = d[0];
    end
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    if (a == 2'd0) m_rxc = 1'b0;
  endtask

  task automatic send_frame(bit nine, logic [8:0] d9, bit stop);
    @(negedge clk);
    nine_bit = nine;
    rx_line = 1'b0;
    repeat (TPB) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx_line = d9[i];
      repeat (TPB) @(negedge clk);
    end
    rx_line = stop;
    repeat (TPB) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    model_frame(nine, d9, stop);
  endtask

  task automatic check_state(string req);
    logic [7:0] v;
    bus_read(2'd1, v); check(req, v, exp_status());
    bus_read(2'd2, v); check(req, v, {7'd0, m_b9});
    checks++;
    if (rx_byte !== m_data) begin
      errors++;
      $display("FAIL %s: rx_byte 0x%02h expected 0x%02h", req, rx_byte, m_data);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    bus_read(2'd1, v); check("R7 reset status", v, 8'h20);
    bus_read(2'd0, v); check("R7 reset data", v, 8'h00);
    bus_read(2'd2, v); check("R10 reset ninth", v, 8'h00);
    check("R7 reset flags", {5'd0, rx_full, frame_err, overrun_flag}, 8'h00);

    // writable status bits
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, v); check("R8 write ones", v, 8'h63);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); check("R8 write zeros", v, 8'h20);

    // shared data address
    bus_write(2'd0, 8'hA5);
    check("R6 tx hold", tx_hold, 8'hA5);
    bus_read(2'd0, v); check("R6 read not tx", v, 8'h00);

    // plain eight-bit receive
    send_frame(1'b0, 9'h03C, 1'b1);
    check_state("R1 eight-bit frame");
    bus_read(2'd0, v); check("R6 read data", v, 8'h3C);
    bus_read(2'd1, v); check("R6 read clears rxc", v, exp_status());

    // eight-bit data byte, filter off: framing error
    send_frame(1'b0, 9'h0C3, 1'b0);
    check_state("R3 stop-low data byte");
    check("R3 fe flag", {7'd0, frame_err}, 8'h01);
    bus_read(2'd0, v); check("R3 data", v, 8'hC3);

    // start glitch shorter than half a bit
    @(negedge clk); rx_line = 1'b0;
    repeat (12) @(negedge clk); rx_line = 1'b1;
    repeat (300) @(negedge clk);
    check_state("R1 start glitch ignored");

    // filter on: data frames dropped
    bus_write(2'd1, 8'h01);
    send_frame(1'b0, 9'h07E, 1'b0);
    check_state("R4 eight-bit data dropped");
    send_frame(1'b1, 9'h0E7, 1'b1);
    check_state("R4 nine-bit data dropped");
    // address accepted
    send_frame(1'b1, 9'h155, 1'b1);
    check_state("R5 address accepted");
    check("R5 rx_full", {7'd0, rx_full}, 8'h01);
    check("R10 ninth bit", {7'd0, m_b9}, 8'h01);
    // overrun on second address before read
    send_frame(1'b0, 9'h0AA, 1'b1);
    check_state("R9 overrun set");
    check("R9 data kept", rx_byte, 8'h55);
    bus_read(2'd0, v); check("R9 read old data", v, 8'h55);
    send_frame(1'b0, 9'h011, 1'b1);
    check_state("R9 overrun cleared");

    // nine-bit with low stop, filter off
    bus_read(2'd0, v);
    bus_write(2'd1, 8'h00);
    send_frame(1'b1, 9'h022, 1'b0);
    check_state("R2 nine-bit framing error");
    bus_read(2'd3, v); check("R10 address 3", v, 8'h00);
    bus_read(2'd0, v); check("R2 nine-bit data", v, 8'h22);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 60; n++) begin
      bit nine, stop;
      logic [8:0] d9;
      nine = ($urandom % 2) == 1;
      d9   = 9'($urandom);
      stop = nine ? (($urandom % 8) != 0) : (($urandom % 2) == 1);
      if (($urandom % 4) == 0)
        bus_write(2'd1, {1'b0, 1'($urandom), 5'd0, 1'($urandom)});
      send_frame(nine, d9, stop);
      check_state(nine ? "R2 random frame" : "R3 random frame");
      if (($urandom % 10) < 7) begin
        logic [7:0] expd;
        expd = m_data;
        bus_read(2'd0, v); check("R6 random read", v, expd);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule